// File: doc/BRIEF.md
# Four-Channel PWM Register Front End

This block sits between a simple 32-bit register bus and four PWM channel cores. It decodes a word address into a small set of global registers and one configuration bank for each channel. Each bank holds a mode word, a duty value, a pending duty value, a period value and a pending period value. The bank contents drive the channel cores continuously.

Channels are started and stopped through two separate write-one-to-act registers. A 1 in bit n of a write produces a one-cycle request pulse to channel n. A 0 bit leaves that channel untouched. A status register reflects the running flags that come back from the cores. An event register collects each core's end-of-period pulses into sticky flags, and a read of that register clears all of them. An event that coincides with the clearing read is kept for the next read.

Reads are registered. Read data appears on the cycle after the read strobe, and the read data output is zero on every cycle that follows no read.

Top module: `pwmfe_top`

## Requirements
- R1: After reset, every channel bank register, every configuration output, the event flags, the start and stop pulses and the read data are all zero.
- R2: A write to offset 0x04 drives `ch_start` with write data bits 3:0 for exactly the one cycle after the write. In all other cycles `ch_start` is zero, and a 0 bit requests nothing.
- R3: A write to offset 0x08 drives `ch_stop` with write data bits 3:0 for exactly the one cycle after the write. In all other cycles `ch_stop` is zero.
- R4: A read of offset 0x0C returns `ch_running` in bits 3:0 and zeros above, on `bus_rdata` in the cycle after `bus_rd`. When there was no read in the previous cycle, `bus_rdata` is zero.
- R5: A pulse on `ch_event[n]` sets bit n of the event register at offset 0x1C. The bit stays set until that register is read.
- R6: A read of offset 0x1C returns the event flags and clears all of them.
- R7: When an event pulse arrives in the same cycle as a read of 0x1C, the read returns the flags as they were before that cycle, and the new event remains set afterwards.
- R8: Channel n's bank starts at 0x200 + n*0x20. Its registers are mode at +0x00, duty at +0x04, pending duty at +0x08, period at +0x0C and pending period at +0x10. Each is a 32-bit read/write word that drives the matching slice n*32 +: 32 of its configuration output.
- R9: Reads of unmapped offsets return zero. Unmapped offsets include unaligned addresses, bank offsets above +0x10, and addresses outside the map. Writes to unmapped offsets change no register and raise no pulse.
- R10: Writes to 0x0C and 0x1C are ignored, and a write to 0x1C does not clear the event flags.
- R11: Reads of the start and stop registers (0x04, 0x08) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ch_running | input | 4 | Running flag from each channel core |
| ch_event | input | 4 | End-of-period pulse from each channel core |
| ch_start | output | 4 | One-cycle start request per channel |
| ch_stop | output | 4 | One-cycle stop request per channel |
| cfg_mode | output | 128 | Mode word for each channel |
| cfg_duty | output | 128 | Duty value for each channel |
| cfg_duty_nxt | output | 128 | Pending duty value for each channel |
| cfg_period | output | 128 | Period value for each channel |
| cfg_period_nxt | output | 128 | Pending period value for each channel |

## Verification
The assertions check several behaviours on every cycle:
- the one-cycle shape and content of the start and stop pulses;
- the idle-zero read data and the status read;
- the setting and stickiness of event flags;
- the clear-on-read rule, including an event that lands during the clearing read.

Only the bench scenarios can show the address map itself. These scenarios cover the placement of every field in every bank and the matching configuration output slice, the rejection of unaligned and out-of-range writes, and the fact that writes to read-only offsets leave state intact. Each of these is shown by a later read-back through the bus.

// File: rtl/pwmfe_pkg.sv
package pwmfe_pkg;
  // Global register offsets (bytes)
  localparam int OFS_START  = 'h04;
  localparam int OFS_STOP   = 'h08;
  localparam int OFS_RUN    = 'h0C;
  localparam int OFS_EVENT  = 'h1C;
  // Channel bank placement
  localparam int BANK_BASE   = 'h200;
  localparam int BANK_STRIDE = 'h20;
  localparam int NUM_FLD     = 5;

  // Field index inside a bank: byte offset / 4
  typedef enum logic [2:0] {
    FLD_MODE      = 3'd0,
    FLD_DUTY      = 3'd1,
    FLD_DUTY_NXT  = 3'd2,
    FLD_PERIOD    = 3'd3,
    FLD_PRD_NXT   = 3'd4
  } fld_e;
endpackage

// File: rtl/pwmfe_chan_bank.sv
module pwmfe_chan_bank
  import pwmfe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  fld_e          fld,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] duty_o,
  output logic [DW-1:0] duty_nxt_o,
  output logic [DW-1:0] period_o,
  output logic [DW-1:0] prd_nxt_o
);
  logic [DW-1:0] mode_q, duty_q, duty_nxt_q, period_q, prd_nxt_q;
  logic [DW-1:0] mode_d, duty_d, duty_nxt_d, period_d, prd_nxt_d;

  always_comb begin
    mode_d     = mode_q;
    duty_d     = duty_q;
    duty_nxt_d = duty_nxt_q;
    period_d   = period_q;
    prd_nxt_d  = prd_nxt_q;
    case (fld)
      FLD_MODE:     mode_d     = wdata;
      FLD_DUTY:     duty_d     = wdata;
      FLD_DUTY_NXT: duty_nxt_d = wdata;
      FLD_PERIOD:   period_d   = wdata;
      FLD_PRD_NXT:  prd_nxt_d  = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      duty_q     <= '0;
      duty_nxt_q <= '0;
      period_q   <= '0;
      prd_nxt_q  <= '0;
    end else if (wr_hit) begin
      mode_q     <= mode_d;
      duty_q     <= duty_d;
      duty_nxt_q <= duty_nxt_d;
      period_q   <= period_d;
      prd_nxt_q  <= prd_nxt_d;
    end
  end

  always_comb begin
    case (fld)
      FLD_MODE:     rd_val = mode_q;
      FLD_DUTY:     rd_val = duty_q;
      FLD_DUTY_NXT: rd_val = duty_nxt_q;
      FLD_PERIOD:   rd_val = period_q;
      FLD_PRD_NXT:  rd_val = prd_nxt_q;
      default:      rd_val = '0;
    endcase
  end

  assign mode_o     = mode_q;
  assign duty_o     = duty_q;
  assign duty_nxt_o = duty_nxt_q;
  assign period_o   = period_q;
  assign prd_nxt_o  = prd_nxt_q;
endmodule

// File: rtl/pwmfe_evt_latch.sv
module pwmfe_evt_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;
  logic         upd_en;

  // A clear drops old flags only; events of the same cycle survive it.
  always_comb begin
    flags_d = (clr_i ? '0 : flags_q) | set_i;
    upd_en  = clr_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pwmfe_top.sv
module pwmfe_top
  import pwmfe_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    ch_running,
  input  logic [NCH-1:0]    ch_event,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_stop,
  output logic [NCH*DW-1:0] cfg_mode,
  output logic [NCH*DW-1:0] cfg_duty,
  output logic [NCH*DW-1:0] cfg_duty_nxt,
  output logic [NCH*DW-1:0] cfg_period,
  output logic [NCH*DW-1:0] cfg_period_nxt
);
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int STRIDE_LG = $clog2(BANK_STRIDE);
  localparam int BANK_END  = BANK_BASE + NCH * BANK_STRIDE;
  localparam logic [AW-1:0] A_START = AW'(OFS_START);
  localparam logic [AW-1:0] A_STOP  = AW'(OFS_STOP);
  localparam logic [AW-1:0] A_RUN   = AW'(OFS_RUN);
  localparam logic [AW-1:0] A_EVENT = AW'(OFS_EVENT);
  localparam logic [AW-1:0] A_BASE  = AW'(BANK_BASE);

  // Address decode
  logic                 bank_hit, fld_vld;
  logic [CH_W-1:0]      bank_idx;
  logic [STRIDE_LG-1:0] fld_ofs;
  fld_e                 fld_sel;

  always_comb begin
    bank_hit = (int'(bus_addr) >= BANK_BASE) && (int'(bus_addr) < BANK_END);
    bank_idx = CH_W'((bus_addr - A_BASE) >> STRIDE_LG);
    fld_ofs  = bus_addr[STRIDE_LG-1:0];
    fld_vld  = bank_hit && (fld_ofs[1:0] == 2'b00) &&
               (int'(fld_ofs[STRIDE_LG-1:2]) < NUM_FLD);
    fld_sel  = fld_e'(fld_ofs[4:2]);
  end

  // Channel banks
  logic [DW-1:0] bank_rd [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_bank
    logic wr_hit;
    assign wr_hit = bus_wr && fld_vld && (bank_idx == CH_W'(g));
    pwmfe_chan_bank #(.DW(DW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit),
      .fld        (fld_sel),
      .wdata      (bus_wdata),
      .rd_val     (bank_rd[g]),
      .mode_o     (cfg_mode[g*DW +: DW]),
      .duty_o     (cfg_duty[g*DW +: DW]),
      .duty_nxt_o (cfg_duty_nxt[g*DW +: DW]),
      .period_o   (cfg_period[g*DW +: DW]),
      .prd_nxt_o  (cfg_period_nxt[g*DW +: DW])
    );
  end

  // Event flags, cleared by a read of the event register
  logic [NCH-1:0] evt_flags;
  logic           evt_clr;

  assign evt_clr = bus_rd && (bus_addr == A_EVENT);

  pwmfe_evt_latch #(.N(NCH)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ch_event),
    .clr_i   (evt_clr),
    .flags_o (evt_flags)
  );

  // Start / stop request pulses
  logic [NCH-1:0] start_q, start_d, stop_q, stop_d;

  always_comb begin
    start_d = (bus_wr && bus_addr == A_START) ? bus_wdata[NCH-1:0] : '0;
    stop_d  = (bus_wr && bus_addr == A_STOP)  ? bus_wdata[NCH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign ch_start = start_q;
  assign ch_stop  = stop_q;

  // Registered read path
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      if (fld_vld)                   rdata_d = bank_rd[bank_idx];
      else if (bus_addr == A_RUN)    rdata_d = DW'(ch_running);
      else if (bus_addr == A_EVENT)  rdata_d = DW'(evt_flags);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwmfe_chk.sv
module pwmfe_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic [DW-1:0]  bus_wdata,
  input logic           bus_rd,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] ch_running,
  input logic [NCH-1:0] ch_event,
  input logic [NCH-1:0] ch_start,
  input logic [NCH-1:0] ch_stop,
  input logic [NCH-1:0] evt_flags
);
  localparam logic [AW-1:0] A_START = AW'('h04);
  localparam logic [AW-1:0] A_STOP  = AW'('h08);
  localparam logic [AW-1:0] A_RUN   = AW'('h0C);
  localparam logic [AW-1:0] A_EVENT = AW'('h1C);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_START) |=> (ch_start == $past(bus_wdata[NCH-1:0])));
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_START) |=> (ch_start == '0));
  p_stop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STOP) |=> (ch_stop == $past(bus_wdata[NCH-1:0])));
  p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STOP) |=> (ch_stop == '0));
  p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RUN) |=> (bus_rdata == DW'($past(ch_running))));
  p_idle_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  p_event_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_event) |=> ((evt_flags & $past(ch_event)) == $past(ch_event)));
  p_event_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == A_EVENT) |=> ((evt_flags & $past(evt_flags)) == $past(evt_flags)));
  p_event_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EVENT) |=> (evt_flags == $past(ch_event)));
  p_event_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EVENT) |=> (bus_rdata == DW'($past(evt_flags))));
endmodule

bind pwmfe_top pwmfe_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .ch_running (ch_running),
  .ch_event   (ch_event),
  .ch_start   (ch_start),
  .ch_stop    (ch_stop),
  .evt_flags  (evt_flags)
);

// File: tb/sim_pwmfe_top.sv
module sim_pwmfe_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [AW-1:0]     bus_addr;
  logic              bus_wr;
  logic [DW-1:0]     bus_wdata;
  logic              bus_rd;
  logic [DW-1:0]     bus_rdata;
  logic [NCH-1:0]    ch_running, ch_event, ch_start, ch_stop;
  logic [NCH*DW-1:0] cfg_mode, cfg_duty, cfg_duty_nxt, cfg_period, cfg_period_nxt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmfe_top #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_running(ch_running), .ch_event(ch_event), .ch_start(ch_start),
    .ch_stop(ch_stop), .cfg_mode(cfg_mode), .cfg_duty(cfg_duty),
    .cfg_duty_nxt(cfg_duty_nxt), .cfg_period(cfg_period),
    .cfg_period_nxt(cfg_period_nxt)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_reg [NCH][5];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write: returns at the negedge after the capturing edge
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] p);
    @(negedge clk);
    ch_event = p;
    @(negedge clk);
    ch_event = '0;
  endtask

  function automatic int bank_addr(input int ch, input int f);
    return 'h200 + ch * 'h20 + f * 4;
  endfunction

  function automatic logic [31:0] cfg_of(input int ch, input int f);
    case (f)
      0:       return cfg_mode[ch*DW +: DW];
      1:       return cfg_duty[ch*DW +: DW];
      2:       return cfg_duty_nxt[ch*DW +: DW];
      3:       return cfg_period[ch*DW +: DW];
      default: return cfg_period_nxt[ch*DW +: DW];
    endcase
  endfunction

  task automatic check_banks(input string req);
    logic [31:0] d;
    for (int ch = 0; ch < NCH; ch++)
      for (int f = 0; f < 5; f++) begin
        rd(bank_addr(ch, f), d);
        chk(req, d, exp_reg[ch][f]);
        chk(req, cfg_of(ch, f), exp_reg[ch][f]);
      end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int unmapped [8];
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    ch_running = '0; ch_event = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int ch = 0; ch < NCH; ch++)
      for (int f = 0; f < 5; f++) exp_reg[ch][f] = '0;
    chk("R1 start", 32'(ch_start), 0);
    chk("R1 stop", 32'(ch_stop), 0);
    chk("R1 rdata", bus_rdata, 0);
    check_banks("R1 banks");
    rd('h1C, d); chk("R1 events", d, 0);

    // R2 / R3: every start and stop pattern
    for (int p = 0; p < 16; p++) begin
      wr('h04, 32'hFFFF_FFF0 | 32'(p));
      chk("R2 start pulse", 32'(ch_start), 32'(p));
      chk("R2 no stop", 32'(ch_stop), 0);
      @(negedge clk);
      chk("R2 start one cycle", 32'(ch_start), 0);
      wr('h08, 32'(p));
      chk("R3 stop pulse", 32'(ch_stop), 32'(p));
      chk("R3 no start", 32'(ch_start), 0);
      @(negedge clk);
      chk("R3 stop one cycle", 32'(ch_stop), 0);
    end

    // R4: every running pattern, and idle read data
    for (int p = 0; p < 16; p++) begin
      ch_running = NCH'(p);
      rd('h0C, d); chk("R4 status", d, 32'(p));
      @(negedge clk);
      chk("R4 idle rdata", bus_rdata, 0);
    end

    // R11: write-only registers read as zero
    rd('h04, d); chk("R11 start reads 0", d, 0);
    rd('h08, d); chk("R11 stop reads 0", d, 0);

    // R8: every field of every bank, two complementary patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int ch = 0; ch < NCH; ch++)
        for (int f = 0; f < 5; f++) begin
          d = 32'h5A00_0C03 ^ (32'(ch) << 12) ^ (32'(f) << 4);
          if (pass == 1) d = ~d;
          exp_reg[ch][f] = d;
          wr(bank_addr(ch, f), d);
        end
      check_banks("R8 bank map");
    end

    // R9: unmapped reads and writes
    unmapped = '{'h000, 'h010, 'h014, 'h202, 'h214, 'h23C, 'h280, 'hFFC};
    foreach (unmapped[i]) begin
      wr(unmapped[i], 32'hFFFF_FFFF);
      chk("R9 no start", 32'(ch_start), 0);
      chk("R9 no stop", 32'(ch_stop), 0);
      rd(unmapped[i], d); chk("R9 unmapped read", d, 0);
    end
    check_banks("R9 banks intact");

    // R5 / R6: every single-shot pattern, then clear
    for (int p = 1; p < 16; p++) begin
      pulse(NCH'(p));
      repeat (2) @(negedge clk);
      rd('h1C, d); chk("R5 event latched", d, 32'(p));
      rd('h1C, d); chk("R6 cleared by read", d, 0);
    end
    // R5: accumulation of separate pulses
    pulse(4'b0001); pulse(4'b0100); pulse(4'b0001);
    rd('h1C, d); chk("R5 sticky accumulate", d, 32'h5);
    rd('h1C, d); chk("R6 clear after accumulate", d, 0);

    // R10: writes to read-only registers ignored
    pulse(4'b0110);
    wr('h1C, 32'h0); wr('h1C, 32'hF);
    wr('h0C, 32'hF);
    ch_running = 4'b1001;
    rd('h1C, d); chk("R10 event write ignored", d, 32'h6);
    rd('h0C, d); chk("R10 status write ignored", d, 32'h9);

    // R7: event coinciding with the clearing read
    for (int c = 1; c < 16; c++) begin
      pulse(4'b0011);
      @(negedge clk);
      bus_addr = AW'('h1C); bus_rd = 1'b1; ch_event = NCH'(c);
      @(negedge clk);
      bus_rd = 1'b0; ch_event = '0;
      chk("R7 read returns old", bus_rdata, 32'h3);
      rd('h1C, d); chk("R7 new event kept", d, 32'(c));
    end

    finish_run();
  end
endmodule